// File: doc/BRIEF.md
# Relative Branch Resolver

This block resolves the short relative branch group of an 8-bit processor core. The core's fetch logic presents one complete two-byte branch at a time: the opcode byte, the signed offset byte that follows it, the address of the opcode, and the current carry and zero flags. The block then returns the address of the next instruction to run, whether the branch was taken, and how many clock states the instruction costs.

Five opcodes are recognised. One is unconditional. The other four test a single flag: carry set, carry clear, zero set or zero clear. The offset byte is two's complement. It is added to the address of the instruction that follows the branch, which is the opcode address plus two, so an assembler stores the programmer's offset less two. All address arithmetic wraps at the top of the address space.

A request is one cycle with `req_vld` high. The result appears on the registered outputs one clock later and holds until the next request. The block only reads the flags and has no path that writes them. Reset is asynchronous, active low, and its release is synchronised inside the block.

Top module: `rbr_top`

## Requirements
- R1: After reset, `rsp_vld`, `rsp_known` and `rsp_taken` are 0, `rsp_pc` is 0 and `rsp_states` is 0.
- R2: `rsp_vld` is high in the cycle after each cycle in which `req_vld` is high, and low otherwise.
- R3: Opcode 8'h18 is always taken, whatever the flags.
- R4: Opcode 8'h38 is taken exactly when carry is 1. Opcode 8'h30 is taken exactly when carry is 0.
- R5: Opcode 8'h28 is taken exactly when zero is 1. Opcode 8'h20 is taken exactly when zero is 0.
- R6: A taken branch yields `rsp_pc` = (`req_pc` + 2 + sign-extended `req_disp`) modulo 2^ADDR_W.
- R7: A recognised branch that is not taken yields `rsp_pc` = (`req_pc` + 2) modulo 2^ADDR_W.
- R8: `rsp_states` is 12 for a taken branch and 7 for a branch that is not taken.
- R9: Any other opcode gives `rsp_known` = 0, `rsp_taken` = 0, `rsp_states` = 0 and `rsp_pc` = `req_pc`.
- R10: While `req_vld` is low, `rsp_known`, `rsp_taken`, `rsp_pc` and `rsp_states` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A branch request is present this cycle |
| req_op | input | 8 | Opcode byte |
| req_disp | input | 8 | Signed offset byte |
| req_pc | input | ADDR_W | Address of the opcode byte |
| req_carry | input | 1 | Carry flag |
| req_zero | input | 1 | Zero flag |
| rsp_vld | output | 1 | A result is presented this cycle |
| rsp_known | output | 1 | The opcode was one of the five branches |
| rsp_taken | output | 1 | The branch was taken |
| rsp_pc | output | ADDR_W | Address of the next instruction |
| rsp_states | output | CNT_W | Clock states the instruction costs |

## Verification
The hardest cases to reach are the wrap-around cases. In these the sum crosses the top or the bottom of the address space, either through a negative offset applied near address 0 or through the fixed step of two applied at 16'hFFFE and 16'hFFFF. The stimulus places the opcode address right at both ends of the space and pairs each address with offsets of 8'h80 and 8'h7F and with values close to them. It runs every conditional opcode under both values of its flag, with the unused flag driven to the opposite value, so that a test of the wrong flag shows up. It also sends requests back to back and with idle gaps, to check both the timing of the response and that the outputs hold between requests.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  typedef enum logic [2:0] {
    BR_NONE   = 3'd0,
    BR_ALWAYS = 3'd1,
    BR_CSET   = 3'd2,
    BR_CCLR   = 3'd3,
    BR_ZSET   = 3'd4,
    BR_ZCLR   = 3'd5
  } br_kind_e;

  localparam logic [7:0] OP_ALWAYS = 8'h18;
  localparam logic [7:0] OP_CSET   = 8'h38;
  localparam logic [7:0] OP_CCLR   = 8'h30;
  localparam logic [7:0] OP_ZSET   = 8'h28;
  localparam logic [7:0] OP_ZCLR   = 8'h20;
endpackage

// File: rtl/rbr_decode.sv
module rbr_decode
  import rbr_pkg::*;
(
  input  logic [7:0] op_i,
  output br_kind_e   kind_o
);
  always_comb begin
    case (op_i)
      OP_ALWAYS: kind_o = BR_ALWAYS;
      OP_CSET:   kind_o = BR_CSET;
      OP_CCLR:   kind_o = BR_CCLR;
      OP_ZSET:   kind_o = BR_ZSET;
      OP_ZCLR:   kind_o = BR_ZCLR;
      default:   kind_o = BR_NONE;
    endcase
  end
endmodule

// File: rtl/rbr_cond.sv
module rbr_cond
  import rbr_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     carry_i,
  input  logic     zero_i,
  output logic     take_o
);
  always_comb begin
    case (kind_i)
      BR_ALWAYS: take_o = 1'b1;
      BR_CSET:   take_o = carry_i;
      BR_CCLR:   take_o = ~carry_i;
      BR_ZSET:   take_o = zero_i;
      BR_ZCLR:   take_o = ~zero_i;
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbr_target.sv
module rbr_target #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [7:0]        disp_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] jump_o
);
  localparam int EXT_W = ADDR_W - 8;
  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[7]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign seq_o  = pc_i + ADDR_W'(2);
  assign jump_o = seq_o + disp_ext;
endmodule

// File: rtl/rbr_top.sv
module rbr_top
  import rbr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 4,
  parameter int TAKEN_T = 12,
  parameter int SKIP_T  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [7:0]        req_op,
  input  logic [7:0]        req_disp,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_carry,
  input  logic              req_zero,
  output logic              rsp_vld,
  output logic              rsp_known,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_pc,
  output logic [CNT_W-1:0]  rsp_states
);
  localparam logic [CNT_W-1:0] T_TAKEN = CNT_W'(TAKEN_T);
  localparam logic [CNT_W-1:0] T_SKIP  = CNT_W'(SKIP_T);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  br_kind_e          kind;
  logic              take;
  logic [ADDR_W-1:0] seq_pc, jump_pc;

  rbr_decode u_dec (.op_i(req_op), .kind_o(kind));
  rbr_cond   u_cnd (.kind_i(kind), .carry_i(req_carry), .zero_i(req_zero), .take_o(take));
  rbr_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i(req_pc), .disp_i(req_disp), .seq_o(seq_pc), .jump_o(jump_pc)
  );

  logic              known_d, taken_d;
  logic [ADDR_W-1:0] pc_d;
  logic [CNT_W-1:0]  states_d;

  always_comb begin
    known_d  = (kind != BR_NONE);
    taken_d  = known_d & take;
    if (!known_d) begin
      pc_d     = req_pc;
      states_d = '0;
    end else if (taken_d) begin
      pc_d     = jump_pc;
      states_d = T_TAKEN;
    end else begin
      pc_d     = seq_pc;
      states_d = T_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_known  <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_pc     <= '0;
      rsp_states <= '0;
    end else if (req_vld) begin
      rsp_known  <= known_d;
      rsp_taken  <= taken_d;
      rsp_pc     <= pc_d;
      rsp_states <= states_d;
    end
  end
endmodule

// File: rtl/rbr_chk.sv
module rbr_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              req_vld,
  input logic [7:0]        req_op,
  input logic              req_carry,
  input logic [ADDR_W-1:0] req_pc,
  input logic              rsp_vld,
  input logic              rsp_known,
  input logic              rsp_taken,
  input logic [ADDR_W-1:0] rsp_pc,
  input logic [CNT_W-1:0]  rsp_states
);
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_vld |=> rsp_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_vld |=> !rsp_vld);
  a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_vld && req_op == 8'h18) |=> rsp_taken);
  a_r4_carry_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_vld && req_op == 8'h38) |=> (rsp_taken == $past(req_carry)));
  a_r7_seq_pc: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_vld && rsp_known && !rsp_taken) |-> (rsp_pc == ADDR_W'($past(req_pc) + ADDR_W'(2))));
  a_r8_taken_cost: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_vld && rsp_taken) |-> (rsp_states == CNT_W'(12)));
  a_r8_skip_cost: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_vld && rsp_known && !rsp_taken) |-> (rsp_states == CNT_W'(7)));
  a_r9_unknown: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_vld && !rsp_known) |-> (!rsp_taken && rsp_states == '0 && rsp_pc == $past(req_pc)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_vld |=> ($stable(rsp_pc) && $stable(rsp_taken) && $stable(rsp_states) && $stable(rsp_known)));
endmodule

bind rbr_top rbr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .req_vld(req_vld), .req_op(req_op),
  .req_carry(req_carry), .req_pc(req_pc), .rsp_vld(rsp_vld),
  .rsp_known(rsp_known), .rsp_taken(rsp_taken), .rsp_pc(rsp_pc),
  .rsp_states(rsp_states)
);

// File: tb/sim_rbr_top.sv
module sim_rbr_top;
  localparam int AW = 16;
  localparam int CW = 4;

  logic          clk, rst_n, req_vld, req_carry, req_zero;
  logic [7:0]    req_op, req_disp;
  logic [AW-1:0] req_pc;
  logic          rsp_vld, rsp_known, rsp_taken;
  logic [AW-1:0] rsp_pc;
  logic [CW-1:0] rsp_states;

  rbr_top u0 (.*);

  typedef struct {
    logic          known;
    logic          taken;
    logic [AW-1:0] pc;
    logic [CW-1:0] states;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  logic [AW-1:0] last_pc;
  logic          sb_on = 0;

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] d,
                                 input logic [AW-1:0] pc, input logic c, input logic z,
                                 input string tag);
    exp_t e;
    logic hit, tk;
    hit = 1; tk = 0;
    case (op)
      8'h18: tk = 1;
      8'h38: tk = c;
      8'h30: tk = !c;
      8'h28: tk = z;
      8'h20: tk = !z;
      default: hit = 0;
    endcase
    e.known = hit; e.taken = tk; e.tag = tag;
    if (!hit) begin e.pc = pc; e.states = 0; end
    else if (tk) begin e.pc = AW'(int'(pc) + 2 + int'($signed(d))); e.states = 12; end
    else begin e.pc = AW'(int'(pc) + 2); e.states = 7; end
    return e;
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] d, input logic [AW-1:0] pc,
                      input logic c, input logic z, input string tag);
    @(negedge clk);
    req_vld = 1; req_op = op; req_disp = d; req_pc = pc; req_carry = c; req_zero = z;
    exp_q.push_back(model(op, d, pc, c, z, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 0; req_op = 8'h18; req_disp = 8'h55; req_pc = 16'h1234;
      req_carry = 1; req_zero = 1;
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (sb_on) begin
      if (rsp_vld) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " known"},  rsp_known, e.known);
          check({e.tag, " taken"},  rsp_taken, e.taken);
          check({e.tag, " pc"},     rsp_pc, e.pc);
          check({e.tag, " states"}, rsp_states, e.states);
        end
      end else begin
        check("R2 response present when expected", exp_q.size(), 0);
        check("R10 pc holds when idle", rsp_pc, last_pc);
      end
      last_pc = rsp_pc;
    end
  end

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    req_vld = 0; req_op = 0; req_disp = 0; req_pc = 0; req_carry = 0; req_zero = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 rsp_vld", rsp_vld, 0);
    check("R1 rsp_known", rsp_known, 0);
    check("R1 rsp_taken", rsp_taken, 0);
    check("R1 rsp_pc", rsp_pc, 0);
    check("R1 rsp_states", rsp_states, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", {rsp_vld, rsp_pc}, 0);
    last_pc = 0;
    sb_on = 1;

    send(8'h18, 8'h10, 16'h1000, 0, 0, "R3 fwd");
    send(8'h18, 8'hFE, 16'h2000, 1, 1, "R3 self");
    send(8'h38, 8'h05, 16'h0100, 1, 0, "R4 cset taken");
    send(8'h38, 8'h05, 16'h0100, 0, 1, "R4 cset skip");
    send(8'h30, 8'hF0, 16'h0200, 0, 1, "R4 cclr taken");
    send(8'h30, 8'hF0, 16'h0200, 1, 0, "R4 cclr skip");
    idle(2);
    send(8'h28, 8'h22, 16'h0300, 0, 1, "R5 zset taken");
    send(8'h28, 8'h22, 16'h0300, 1, 0, "R5 zset skip");
    send(8'h20, 8'h80, 16'h0400, 1, 0, "R5 zclr taken");
    send(8'h20, 8'h80, 16'h0400, 0, 1, "R5 zclr skip");
    idle(3);
    send(8'h18, 8'h80, 16'h0010, 0, 0, "R6 wrap low");
    send(8'h18, 8'h7F, 16'hFFF0, 0, 0, "R6 wrap high");
    send(8'h18, 8'h00, 16'hFFFF, 0, 0, "R6 pc top");
    send(8'h38, 8'h40, 16'hFFFE, 0, 0, "R7 wrap skip");
    send(8'h20, 8'h40, 16'hFFFF, 1, 1, "R7 top skip R8");
    send(8'h00, 8'h12, 16'hABCD, 1, 1, "R9 nop");
    send(8'h19, 8'h12, 16'h4321, 0, 0, "R9 near");
    send(8'hFF, 8'h80, 16'hFFFF, 1, 0, "R9 all ones");
    idle(4);
    send(8'h18, 8'h03, 16'h5000, 0, 0, "R10 before gap");
    idle(5);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] op;
      case (k % 6)
        0: op = 8'h18; 1: op = 8'h38; 2: op = 8'h30;
        3: op = 8'h28; 4: op = 8'h20; default: op = 8'(k * 37);
      endcase
      send(op, 8'(k * 53), 16'(k * 4099), k[0], k[1], "R8 sweep");
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    check("R2 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule